// File: doc/BRIEF.md
# Weighted Priority DMA Channel Arbiter

This block decides which of 32 DMA channels receives the next transfer slot. Each channel raises a one-bit request; in any cycle where at least one request is present, the arbiter issues a single grant as a one-hot vector, an encoded channel index and a valid strobe. All three are combinational in that same cycle. The grant lasts one cycle, and the arbiter moves its state on the following clock edge.

The channels form four interleaved priority sets of eight. A channel's set is given by bits [3:2] of its index, so each set owns two runs of four consecutive channels, one in each half of the channel range. Service is shared by a slot scheduler. It is a state machine with eight named states, SL0_HI, SL1_MID, SL2_HI, SL3_LOW2, SL4_HI, SL5_MID, SL6_HI and SL7_LOW3, which name sets 0,1,0,2,0,1,0,3 in that order. As a result, set 0 gets four of every eight slots, set 1 gets two, and sets 2 and 3 get one each. The scheduler takes the transition to the next state in the ring (SL7_LOW3 wraps to SL0_HI) on every cycle that issues a grant. It holds its state on every idle cycle. When the scheduled set has no request, the slot goes to the lowest-numbered set that does have one. Inside each set, a round-robin pointer rotates over the set's eight members.

Top module: `dma_wrr_arbiter`

## Requirements
- R1: Channel c belongs to set (c >> 2) & 3. Member k (0..7) of set s is channel (k / 4) * 16 + s * 4 + (k % 4), so the member order of set 0 is 0,1,2,3,16,17,18,19.
- R2: With every channel requesting, eight consecutive grants starting from slot 0 come from sets 0,1,0,2,0,1,0,3 in that order, which gives shares of 4, 2, 1 and 1.
- R3: When the scheduled set has no request but another set does, the grant goes to the lowest-numbered set that has a request.
- R4: With no request, grant_valid_o is 0, grant_o is all zeros, and the schedule slot does not change.
- R5: Within the winning set, the granted member is the first requesting member at or after that set's pointer, wrapping modulo 8. After a grant, that set's pointer becomes the granted member plus one (mod 8). The pointers of the other sets stay where they are.
- R6: When a request is present, grant_valid_o is 1 in the same cycle. grant_o is then one-hot with its single set bit at grant_idx_o, and that channel is requesting.
- R7: Reset sets every pointer to member 0 and the schedule to slot 0, so the first grant with all channels requesting goes to channel 0.
- R8: The schedule slot advances by one (mod 8) on every granted cycle, including cycles where the slot was handed to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 32 | Per-channel request bits |
| grant_o | output | 32 | One-hot grant, zero when idle |
| grant_idx_o | output | 5 | Encoded index of the granted channel |
| grant_valid_o | output | 1 | High when a grant is issued this cycle |

## Verification
The assertions assume that req_i is stable around each rising clock edge, that it is free of X once reset is released, and that a grant is consumed in the cycle it appears. No requester is assumed to hold its request until it is served. The bench changes req_i only on falling edges and samples outputs two nanoseconds later. It covers all-request bursts, idle gaps, every single-channel pattern and a long run of sparse pseudo-random masks. Each sample is compared with an arithmetic model of the slot ring and the per-set pointers.

// File: rtl/dma_wrr_pkg.sv
`timescale 1ns/1ps
package dma_wrr_pkg;

    localparam int unsigned SET_W = 2;

    // Eight-slot ring; the state name carries the set it serves.
    typedef enum logic [2:0] {
        SL0_HI   = 3'd0,
        SL1_MID  = 3'd1,
        SL2_HI   = 3'd2,
        SL3_LOW2 = 3'd3,
        SL4_HI   = 3'd4,
        SL5_MID  = 3'd5,
        SL6_HI   = 3'd6,
        SL7_LOW3 = 3'd7
    } slot_e;

endpackage

// File: rtl/dma_wrr_set_rr.sv
`timescale 1ns/1ps
module dma_wrr_set_rr #(
    parameter int unsigned MEMBERS = 8,
    localparam int unsigned MW     = $clog2(MEMBERS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MEMBERS-1:0] req,
    input  logic               take,
    output logic               any,
    output logic [MW-1:0]      pick
);

    logic [MW-1:0] ptr;
    logic          found;

    // First requester at or after the pointer, wrapping.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < int'(MEMBERS); i++) begin
            int unsigned k;
            k = (int'(ptr) + i) % MEMBERS;
            if (!found && req[k]) begin
                found = 1'b1;
                pick  = MW'(k);
            end
        end
    end

    assign any = |req;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (take)
            ptr <= pick + MW'(1);
    end

    // R5: a pointer only moves for its own set's grant
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(ptr));

    // R5: a set is only granted when it has a requester
    p_take_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> any);

endmodule

// File: rtl/dma_wrr_slot_fsm.sv
`timescale 1ns/1ps
module dma_wrr_slot_fsm
    import dma_wrr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [SET_W-1:0] sched_set
);

    slot_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SL0_HI;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (adv) begin
            unique case (state)
                SL0_HI:   state_nx = SL1_MID;
                SL1_MID:  state_nx = SL2_HI;
                SL2_HI:   state_nx = SL3_LOW2;
                SL3_LOW2: state_nx = SL4_HI;
                SL4_HI:   state_nx = SL5_MID;
                SL5_MID:  state_nx = SL6_HI;
                SL6_HI:   state_nx = SL7_LOW3;
                SL7_LOW3: state_nx = SL0_HI;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            SL0_HI, SL2_HI, SL4_HI, SL6_HI: sched_set = 2'd0;
            SL1_MID, SL5_MID:               sched_set = 2'd1;
            SL3_LOW2:                       sched_set = 2'd2;
            SL7_LOW3:                       sched_set = 2'd3;
        endcase
    end

    // R4: idle cycles leave the slot untouched
    p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state));

    // R8: each grant steps the ring by one
    p_slot_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (3'(state) == 3'(3'($past(state)) + 3'd1)));

endmodule

// File: rtl/dma_wrr_arbiter.sv
`timescale 1ns/1ps
module dma_wrr_arbiter
    import dma_wrr_pkg::*;
#(
    parameter int unsigned NUM_CH   = 32,
    parameter int unsigned NUM_SETS = 4,
    parameter int unsigned RUN      = 4,
    localparam int unsigned MEMBERS = NUM_CH / NUM_SETS,
    localparam int unsigned MW      = $clog2(MEMBERS),
    localparam int unsigned IDX_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic [IDX_W-1:0]  grant_idx_o,
    output logic              grant_valid_o
);

    logic [MEMBERS-1:0]  set_req [NUM_SETS];
    logic [MW-1:0]       set_pick [NUM_SETS];
    logic [NUM_SETS-1:0] set_any;
    logic [SET_W-1:0]    sched_set;
    logic [SET_W-1:0]    win_set;
    logic                any_req;

    // Gather each set's members from the interleaved channel runs.
    for (genvar s = 0; s < int'(NUM_SETS); s++) begin : g_set
        for (genvar k = 0; k < int'(MEMBERS); k++) begin : g_mem
            localparam int unsigned CH = (k / RUN) * RUN * NUM_SETS + s * RUN + (k % RUN);
            assign set_req[s][k] = req_i[CH];
        end

        dma_wrr_set_rr #(.MEMBERS(MEMBERS)) u_rr (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (set_req[s]),
            .take (any_req && (win_set == SET_W'(s))),
            .any  (set_any[s]),
            .pick (set_pick[s])
        );
    end

    assign any_req = |set_any;

    dma_wrr_slot_fsm u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (any_req),
        .sched_set(sched_set)
    );

    // Scheduled set if it has work, else the lowest-numbered busy set.
    always_comb begin
        win_set = '0;
        for (int s = int'(NUM_SETS) - 1; s >= 0; s--) begin
            if (set_any[s])
                win_set = SET_W'(s);
        end
        if (set_any[sched_set])
            win_set = sched_set;
    end

    always_comb begin
        int unsigned k;
        int unsigned ch;
        k  = int'(set_pick[win_set]);
        ch = (k / RUN) * RUN * NUM_SETS + int'(win_set) * RUN + (k % RUN);
        grant_valid_o = any_req;
        grant_idx_o   = any_req ? IDX_W'(ch) : '0;
        grant_o       = any_req ? (NUM_CH'(1) << ch) : '0;
    end

    // R6: exactly one grant bit while valid
    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> ($countones(grant_o) == 1));

    // R6: only requesting channels are granted
    p_grant_requested_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

    // R4: idle means no grant bits
    p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid_o |-> (grant_o == '0));

    // R2: a busy scheduled set is served on its own slot (R1 mapping)
    p_sched_honoured_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && set_any[sched_set]) |->
            (((int'(grant_idx_o) / RUN) % NUM_SETS) == int'(sched_set)));

endmodule

// File: tb/sim_dma_wrr_arbiter.sv
`timescale 1ns/1ps
module sim_dma_wrr_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_i = '0;
    logic [31:0] grant_o;
    logic [4:0]  grant_idx_o;
    logic        grant_valid_o;

    int total = 0;
    int bad   = 0;
    int m_slot = 0;
    int m_ptr [4] = '{0, 0, 0, 0};
    int set_cnt [4];
    logic finished = 1'b0;

    always #10 clk = ~clk;

    dma_wrr_arbiter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .grant_o      (grant_o),
        .grant_idx_o  (grant_idx_o),
        .grant_valid_o(grant_valid_o)
    );

    function automatic int mem_ch(int s, int k);
        return (k / 4) * 16 + s * 4 + (k % 4);
    endfunction

    function automatic int sched_of(int slot);
        if (slot % 2 == 0) return 0;
        if (slot == 1 || slot == 5) return 1;
        if (slot == 3) return 2;
        return 3;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive on the falling edge, compare, then advance the model as the next rising edge will.
    task automatic step(input logic [31:0] r, output int gidx);
        int sch, win, pk, ech;
        bit any [4];
        string tag;
        @(negedge clk);
        req_i = r;
        #2;
        gidx = -1;
        if (r == 0) begin
            chk(grant_valid_o == 1'b0, "R4 valid", int'(grant_valid_o), 0);
            chk(grant_o == 32'd0, "R4 grant", int'(grant_o), 0);
        end else begin
            for (int s = 0; s < 4; s++) begin
                any[s] = 1'b0;
                for (int k = 0; k < 8; k++) if (r[mem_ch(s, k)]) any[s] = 1'b1;
            end
            sch = sched_of(m_slot);
            win = -1;
            if (any[sch]) begin win = sch; tag = "R5"; end
            else begin
                for (int s = 3; s >= 0; s--) if (any[s]) win = s;
                tag = "R3";
            end
            pk = 0;
            for (int i = 7; i >= 0; i--) if (r[mem_ch(win, (m_ptr[win] + i) % 8)]) pk = (m_ptr[win] + i) % 8;
            ech = mem_ch(win, pk);
            chk(grant_valid_o == 1'b1, "R6 valid", int'(grant_valid_o), 1);
            chk(int'(grant_idx_o) == ech, tag, int'(grant_idx_o), ech);
            chk(grant_o == (32'd1 << grant_idx_o), "R6 onehot", int'(grant_o), int'(32'd1 << grant_idx_o));
            gidx = ech;
            m_ptr[win] = (pk + 1) % 8;
            m_slot = (m_slot + 1) % 8;
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int g;
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: first grant after reset with all requests is channel 0
        step(32'hFFFF_FFFF, g);
        chk(g == 0 && grant_idx_o == 5'd0, "R7 first", int'(grant_idx_o), 0);

        // R2: shares over the next 16 grants with all requesting
        for (int s = 0; s < 4; s++) set_cnt[s] = 0;
        for (int n = 0; n < 16; n++) begin
            step(32'hFFFF_FFFF, g);
            if (g >= 0) set_cnt[(g >> 2) & 3]++;
        end
        chk(set_cnt[0] == 8, "R2 set0", set_cnt[0], 8);
        chk(set_cnt[1] == 4, "R2 set1", set_cnt[1], 4);
        chk(set_cnt[2] == 2, "R2 set2", set_cnt[2], 2);
        chk(set_cnt[3] == 2, "R2 set3", set_cnt[3], 2);

        // R4 / R8: idle gap holds slot, then fallback advances it
        repeat (5) step(32'd0, g);
        step(32'h0000_2000, g);
        chk(g == 13, "R3 fallback", g, 13);
        step(32'hFFFF_FFFF, g);
        chk(m_slot >= 0, "R8 ring", m_slot, m_slot);

        // R1: every single channel maps to its own set and is granted
        for (int c = 0; c < 32; c++) begin
            step(32'd1 << c, g);
            chk(grant_idx_o[3:2] == 2'((c >> 2) & 3), "R1 set", int'(grant_idx_o[3:2]), (c >> 2) & 3);
        end

        // Sparse pseudo-random masks across all requirements
        lfsr = 32'hACE1_2357;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr & {lfsr[15:0], lfsr[31:16]} & ((n % 7 == 0) ? 32'd0 : 32'hFFFF_FFFF), g);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule